// File: doc/BRIEF.md
# Cascaded Two-Level DMA Request Controller

This block arbitrates DMA requests from eight peripheral channels and turns the winning request into one memory beat. Two four-channel controllers are stacked. The lower, slave controller serves byte channels 0 to 3. The upper, master controller serves word channels 4 to 7. The master's local channel 0 (global channel 4) has no peripheral of its own: it carries the combined request of the slave controller. When any enabled request is present, the block asks the bus owner for the bus. Once the bus is granted, it picks a channel, acknowledges it, presents the physical address and direction to memory, and then steps that channel's address and count.

A host writes each channel's page, address, count, mode and mask through a narrow byte-wide write port. Addresses and counts are 16 bits wide and are loaded as two byte writes in sequence, steered by a per-controller byte-pointer flip-flop. When a channel's count runs out, the channel either masks itself or reloads from its base registers, depending on its auto-initialise bit. A one-cycle terminal-count pulse marks the transfer on which this happens.

The controller runs a five-state machine:
- `ST_IDLE`: no bus held.
- `ST_HOLD`: bus requested, waiting for the grant.
- `ST_SELECT`: arbitration.
- `ST_MEM`: memory beat outstanding.
- `ST_UPDATE`: register step and terminal count.

Its transitions are:
- idle-to-hold, when an enabled request appears.
- hold-to-idle, when the requests vanish.
- hold-to-select, on the grant.
- select-to-idle, when nothing can be served.
- select-to-mem, for read and write types.
- select-to-update, for verify and illegal types.
- mem-to-update, on the memory acknowledge.
- update-to-idle, always.

Top module: `dma_cascade_pair`

## Requirements
- R1: After reset every channel mask bit on both controllers is set, both byte-pointer flip-flops point at the low byte, and `hold_req`, `dack`, `mem_req` and `tc_pulse` are all 0 even when every `dreq` line is high.
- R2: A host write takes `reg_chan` (bit 2 selects the master, bits 1:0 the local channel) and `reg_field`. The field codes are: 0 address, 1 count, 2 page, 3 mode, 4 mask, 5 flip-flop clear. Address and count writes load the low byte when the controller's flip-flop is 0 and the high byte when it is 1, write the base and current copies together, and toggle the flip-flop. Code 5 returns it to the low byte. The mode byte holds the transfer type in bits 1:0 and auto-initialise in bit 2. The mask write copies `reg_wdata[0]` into the channel's mask.
- R3: `hold_req` is high whenever an enabled request exists and during a granted transfer. A slave request counts only if its own mask is clear and master channel 4's mask is clear.
- R4: Arbitration searches the master channels from local 0 upward. If local 0 (the cascade) wins, it searches slave channels 0 to 3 upward. The winner's `dack` bit is raised, and for a slave winner `dack[4]` is raised with it.
- R5: `dreq[4]` has no effect: it never raises `hold_req` or produces a transfer.
- R6: `mem_addr` is the channel's 8-bit page above its 16-bit current address. `mem_word` is 1 for channels 4 to 7 and 0 for channels 0 to 3.
- R7: Type 1 performs a memory write (`mem_we`=1) and type 2 a memory read (`mem_we`=0). Types 0 and 3 raise `dack` without any memory request, yet still step the channel.
- R8: Each transfer increments the channel's current address (wrapping within 16 bits, page unchanged) and decrements its current count.
- R9: `tc_pulse` is high for exactly one cycle, together with `dack`, on a transfer whose current count was 0. Without auto-initialise, that transfer sets the channel's mask bit.
- R10: With auto-initialise, a transfer at count 0 reloads the current address and count from the base registers and leaves the mask clear.
- R11: `mem_req` stays high with a stable `mem_addr` until `mem_ack`, so a beat may take any number of cycles.
- R12: After each transfer, `dack` (including the cascade `dack[4]`) and `mem_req` fall, and the block re-arbitrates from idle.
- R13: No `dack` and no `mem_req` appear while `hold_ack` is low. The bus owner is expected to keep `hold_ack` high while `hold_req` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dreq | input | 8 | Per-channel request, bit n = channel n |
| hold_req | output | 1 | Bus request to the bus owner |
| hold_ack | input | 1 | Bus grant from the bus owner |
| reg_we | input | 1 | Host register write strobe |
| reg_chan | input | 3 | Host target channel |
| reg_field | input | 3 | Host target field code |
| reg_wdata | input | 8 | Host write data |
| dack | output | 8 | Per-channel acknowledge |
| mem_req | output | 1 | Memory beat request |
| mem_we | output | 1 | 1 = write into memory, 0 = read from memory |
| mem_word | output | 1 | 1 = 16-bit beat, 0 = 8-bit beat |
| mem_addr | output | 24 | Physical address {page, current address} |
| mem_ack | input | 1 | Memory beat accepted |
| tc_pulse | output | 1 | Terminal count, one cycle |

## Verification
Arbitration is swept over all 256 values of the eight request lines, twice: once with the cascade channel enabled and once with it masked. This separates slave-before-master ordering, ascending order inside each controller, the ignored line 4 and cascade gating from one another. Each channel is then driven alone through a count of three from an address next to the 16-bit wrap. This separates address stepping, the terminal-count transfer, masking without auto-initialise and reloading with it.

Directed sequences cover the remaining cases:
- The reset value of the byte pointer and its explicit clear.
- Operation with the grant withheld.
- Memory acknowledges delayed by several cycles.

Every transfer type, including the illegal one, is compared against an arithmetic model of page, address and count.

// File: rtl/dmac_pkg.sv
package dmac_pkg;

    localparam int DMAC_NCH = 4;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_HOLD   = 3'd1,
        ST_SELECT = 3'd2,
        ST_MEM    = 3'd3,
        ST_UPDATE = 3'd4
    } dmac_state_e;

    localparam logic [2:0] FLD_ADDR  = 3'd0;
    localparam logic [2:0] FLD_COUNT = 3'd1;
    localparam logic [2:0] FLD_PAGE  = 3'd2;
    localparam logic [2:0] FLD_MODE  = 3'd3;
    localparam logic [2:0] FLD_MASK  = 3'd4;
    localparam logic [2:0] FLD_FFCLR = 3'd5;

    localparam logic [1:0] XT_VERIFY   = 2'd0;
    localparam logic [1:0] XT_TO_MEM   = 2'd1;
    localparam logic [1:0] XT_FROM_MEM = 2'd2;
    localparam logic [1:0] XT_ILLEGAL  = 2'd3;

    typedef struct packed {
        logic       autoinit;
        logic [1:0] xtype;
    } dmac_mode_t;

endpackage

// File: rtl/dmac_prio.sv
module dmac_prio #(
    parameter int N = 4
) (
    input  logic [N-1:0]         req,
    output logic                 found,
    output logic [$clog2(N)-1:0] idx
);
    localparam int IW = $clog2(N);

    // lowest index wins: scan downward so the last hit is the smallest
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                found = 1'b1;
                idx   = IW'(i);
            end
        end
    end
endmodule

// File: rtl/dmac_ctl.sv
module dmac_ctl
    import dmac_pkg::*;
#(
    parameter int NCH = 4,
    parameter int AW  = 16,
    parameter int PW  = 8,
    parameter int DW  = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [2:0]               wr_field,
    input  logic [$clog2(NCH)-1:0]   wr_chan,
    input  logic [DW-1:0]            wr_data,
    input  logic                     step_en,
    input  logic [$clog2(NCH)-1:0]   step_chan,
    output logic [NCH-1:0]           mask,
    output logic [NCH-1:0][AW-1:0]   cur_addr,
    output logic [NCH-1:0][AW-1:0]   cur_count,
    output logic [NCH-1:0][PW-1:0]   page,
    output logic [NCH-1:0][1:0]      xtype
);
    localparam int HW = AW - DW;

    logic ff_q;

    // byte pointer shared by every address and count register of this controller
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ff_q <= 1'b0;
        end else if (wr_en) begin
            if (wr_field == FLD_FFCLR) begin
                ff_q <= 1'b0;
            end else if (wr_field == FLD_ADDR || wr_field == FLD_COUNT) begin
                ff_q <= ~ff_q;
            end
        end
    end

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        logic              m_q;
        logic [AW-1:0]     ba_q, ca_q, bc_q, cc_q;
        logic [PW-1:0]     pg_q;
        dmac_mode_t        md_q;
        logic              wr_hit, step_hit, expire;

        assign wr_hit   = wr_en && (wr_chan == c);
        assign step_hit = step_en && (step_chan == c);
        assign expire   = (cc_q == '0);

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                m_q  <= 1'b1;
                ba_q <= '0;
                ca_q <= '0;
                bc_q <= '0;
                cc_q <= '0;
                pg_q <= '0;
                md_q <= '0;
            end else begin
                if (step_hit) begin
                    if (expire && md_q.autoinit) begin
                        ca_q <= ba_q;
                        cc_q <= bc_q;
                    end else begin
                        ca_q <= ca_q + 1'b1;
                        cc_q <= cc_q - 1'b1;
                    end
                    if (expire && !md_q.autoinit) begin
                        m_q <= 1'b1;
                    end
                end
                // a host write in the same cycle takes precedence
                if (wr_hit) begin
                    case (wr_field)
                        FLD_ADDR: begin
                            if (ff_q) begin
                                ba_q[AW-1:DW] <= wr_data[HW-1:0];
                                ca_q[AW-1:DW] <= wr_data[HW-1:0];
                            end else begin
                                ba_q[DW-1:0] <= wr_data;
                                ca_q[DW-1:0] <= wr_data;
                            end
                        end
                        FLD_COUNT: begin
                            if (ff_q) begin
                                bc_q[AW-1:DW] <= wr_data[HW-1:0];
                                cc_q[AW-1:DW] <= wr_data[HW-1:0];
                            end else begin
                                bc_q[DW-1:0] <= wr_data;
                                cc_q[DW-1:0] <= wr_data;
                            end
                        end
                        FLD_PAGE: pg_q <= wr_data[PW-1:0];
                        FLD_MODE: md_q <= dmac_mode_t'(wr_data[2:0]);
                        FLD_MASK: m_q  <= wr_data[0];
                        default: begin
                        end
                    endcase
                end
            end
        end

        assign mask[c]      = m_q;
        assign cur_addr[c]  = ca_q;
        assign cur_count[c] = cc_q;
        assign page[c]      = pg_q;
        assign xtype[c]     = md_q.xtype;
    end
endmodule

// File: rtl/dma_cascade_pair.sv
module dma_cascade_pair
    import dmac_pkg::*;
#(
    parameter int AW = 16,
    parameter int PW = 8,
    parameter int DW = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [2*DMAC_NCH-1:0]   dreq,
    output logic                    hold_req,
    input  logic                    hold_ack,
    input  logic                    reg_we,
    input  logic [2:0]              reg_chan,
    input  logic [2:0]              reg_field,
    input  logic [DW-1:0]           reg_wdata,
    output logic [2*DMAC_NCH-1:0]   dack,
    output logic                    mem_req,
    output logic                    mem_we,
    output logic                    mem_word,
    output logic [PW+AW-1:0]        mem_addr,
    input  logic                    mem_ack,
    output logic                    tc_pulse
);
    localparam int NCH = DMAC_NCH;
    localparam int CW  = $clog2(NCH);

    // ---------------- per-controller register files ----------------
    logic [NCH-1:0]          s_mask, m_mask;
    logic [NCH-1:0][AW-1:0]  s_addr, m_addr, s_cnt, m_cnt;
    logic [NCH-1:0][PW-1:0]  s_page, m_page;
    logic [NCH-1:0][1:0]     s_xt, m_xt;
    logic                    s_step, m_step;
    logic [CW:0]             sel_chan;
    logic [1:0]              sel_type;

    dmac_ctl #(.NCH(NCH), .AW(AW), .PW(PW), .DW(DW)) u_slave (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (reg_we && !reg_chan[CW]),
        .wr_field  (reg_field),
        .wr_chan   (reg_chan[CW-1:0]),
        .wr_data   (reg_wdata),
        .step_en   (s_step),
        .step_chan (sel_chan[CW-1:0]),
        .mask      (s_mask),
        .cur_addr  (s_addr),
        .cur_count (s_cnt),
        .page      (s_page),
        .xtype     (s_xt)
    );

    dmac_ctl #(.NCH(NCH), .AW(AW), .PW(PW), .DW(DW)) u_master (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (reg_we && reg_chan[CW]),
        .wr_field  (reg_field),
        .wr_chan   (reg_chan[CW-1:0]),
        .wr_data   (reg_wdata),
        .step_en   (m_step),
        .step_chan (sel_chan[CW-1:0]),
        .mask      (m_mask),
        .cur_addr  (m_addr),
        .cur_count (m_cnt),
        .page      (m_page),
        .xtype     (m_xt)
    );

    // ---------------- request gathering and arbitration ----------------
    logic [NCH-1:0] s_pend, m_raw, m_pend;
    logic           any_pend;
    logic           s_found, m_found, pick_ok;
    logic [CW-1:0]  s_idx, m_idx;
    logic [CW:0]    pick_chan;
    logic [1:0]     pick_type;
    logic           unused_cascade_line;

    assign unused_cascade_line = dreq[NCH];  // local 0 of the master is the cascade input

    assign s_pend   = dreq[NCH-1:0] & ~s_mask;
    assign m_raw    = {dreq[2*NCH-1:NCH+1], |s_pend};
    assign m_pend   = m_raw & ~m_mask;
    assign any_pend = |m_pend;

    dmac_prio #(.N(NCH)) u_mprio (.req(m_pend), .found(m_found), .idx(m_idx));
    dmac_prio #(.N(NCH)) u_sprio (.req(s_pend), .found(s_found), .idx(s_idx));

    assign pick_chan = (m_idx == '0) ? {1'b0, s_idx} : {1'b1, m_idx};
    assign pick_ok   = m_found && ((m_idx != '0) || s_found);
    assign pick_type = pick_chan[CW] ? m_xt[pick_chan[CW-1:0]] : s_xt[pick_chan[CW-1:0]];

    // ---------------- selected channel view ----------------
    logic            sel_master;
    logic [CW-1:0]   sel_loc;
    logic [AW-1:0]   sel_addr, sel_count;
    logic [PW-1:0]   sel_page;

    assign sel_master = sel_chan[CW];
    assign sel_loc    = sel_chan[CW-1:0];
    assign sel_addr   = sel_master ? m_addr[sel_loc] : s_addr[sel_loc];
    assign sel_count  = sel_master ? m_cnt[sel_loc]  : s_cnt[sel_loc];
    assign sel_page   = sel_master ? m_page[sel_loc] : s_page[sel_loc];

    // ---------------- state machine ----------------
    dmac_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_chan <= '0;
            sel_type <= XT_VERIFY;
        end else if (state_q == ST_SELECT) begin
            sel_chan <= pick_chan;
            sel_type <= pick_type;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (any_pend) state_d = ST_HOLD;
            end
            ST_HOLD: begin
                if (!any_pend)     state_d = ST_IDLE;
                else if (hold_ack) state_d = ST_SELECT;
            end
            ST_SELECT: begin
                if (!pick_ok) begin
                    state_d = ST_IDLE;
                end else if (pick_type == XT_TO_MEM || pick_type == XT_FROM_MEM) begin
                    state_d = ST_MEM;
                end else begin
                    state_d = ST_UPDATE;
                end
            end
            ST_MEM: begin
                if (mem_ack) state_d = ST_UPDATE;
            end
            ST_UPDATE: begin
                state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        hold_req = any_pend;
        dack     = '0;
        mem_req  = 1'b0;
        tc_pulse = 1'b0;
        s_step   = 1'b0;
        m_step   = 1'b0;
        unique case (state_q)
            ST_IDLE, ST_HOLD, ST_SELECT: begin
            end
            ST_MEM: begin
                hold_req       = 1'b1;
                mem_req        = 1'b1;
                dack[sel_chan] = 1'b1;
                if (!sel_master) dack[NCH] = 1'b1;
            end
            ST_UPDATE: begin
                hold_req       = 1'b1;
                dack[sel_chan] = 1'b1;
                if (!sel_master) dack[NCH] = 1'b1;
                tc_pulse       = (sel_count == '0);
                s_step         = !sel_master;
                m_step         = sel_master;
            end
            default: begin
            end
        endcase
    end

    assign mem_we   = mem_req && (sel_type == XT_TO_MEM);
    assign mem_word = mem_req && sel_master;
    assign mem_addr = {sel_page, sel_addr};

endmodule

// File: rtl/dmac_checker.sv
module dmac_checker #(
    parameter int MAW = 24
) (
    input logic           clk,
    input logic           rst_n,
    input logic           hold_req,
    input logic           hold_ack,
    input logic [7:0]     dack,
    input logic           mem_req,
    input logic           mem_ack,
    input logic [MAW-1:0] mem_addr,
    input logic           tc_pulse
);
    AST_CASCADE_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (|dack[3:0]) |-> dack[4]);                                   // R4
    AST_CASCADE_NEEDS_SLAVE: assert property (@(posedge clk) disable iff (!rst_n)
        dack[4] |-> (|dack[3:0]));                                   // R4
    AST_SINGLE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(dack & 8'hEF) <= 1);                              // R4
    AST_TC_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        tc_pulse |=> !tc_pulse);                                     // R9
    AST_TC_IN_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        tc_pulse |-> (|dack));                                       // R9
    AST_MEM_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));   // R11
    AST_MEM_UNDER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (hold_req && hold_ack));                         // R13
    AST_DACK_UNDER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (|dack) |-> hold_ack);                                       // R13
endmodule

bind dma_cascade_pair dmac_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .hold_req (hold_req),
    .hold_ack (hold_ack),
    .dack     (dack),
    .mem_req  (mem_req),
    .mem_ack  (mem_ack),
    .mem_addr (mem_addr),
    .tc_pulse (tc_pulse)
);

// File: tb/dma_cascade_pair_tb.sv
module dma_cascade_pair_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  dreq = '0;
    logic        hold_req;
    logic        hold_ack = 1'b1;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_chan = '0;
    logic [2:0]  reg_field = '0;
    logic [7:0]  reg_wdata = '0;
    logic [7:0]  dack;
    logic        mem_req, mem_we, mem_word;
    logic [23:0] mem_addr;
    logic        mem_ack = 1'b0;
    logic        tc_pulse;

    int n_chk = 0;
    int n_fail = 0;
    int ack_lat = 0;
    bit done = 0;

    always #5 clk = ~clk;

    dma_cascade_pair u_dut (
        .clk(clk), .rst_n(rst_n), .dreq(dreq), .hold_req(hold_req), .hold_ack(hold_ack),
        .reg_we(reg_we), .reg_chan(reg_chan), .reg_field(reg_field), .reg_wdata(reg_wdata),
        .dack(dack), .mem_req(mem_req), .mem_we(mem_we), .mem_word(mem_word),
        .mem_addr(mem_addr), .mem_ack(mem_ack), .tc_pulse(tc_pulse)
    );

    // reference model of the channel registers
    logic [7:0]  mdl_mask;
    logic [7:0]  mdl_page [8];
    logic [15:0] mdl_cur  [8];
    logic [15:0] mdl_base [8];
    logic [15:0] mdl_cnt  [8];
    logic [15:0] mdl_bcnt [8];
    logic [1:0]  mdl_type [8];
    logic        mdl_auto [8];

    task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
        end
    endtask

    // memory responder with programmable latency
    initial begin
        int wcnt = 0;
        forever begin
            @(negedge clk);
            if (mem_req && !mem_ack) begin
                if (wcnt >= ack_lat) mem_ack = 1'b1;
                else wcnt++;
            end else begin
                mem_ack = 1'b0;
                wcnt = 0;
            end
        end
    end

    task automatic host_wr(input logic [2:0] ch, input logic [2:0] fld, input logic [7:0] d);
        reg_chan = ch; reg_field = fld; reg_wdata = d; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic set_mask(input int c, input logic v);
        host_wr(3'(c), 3'd4, {7'd0, v});
        mdl_mask[c] = v;
    endtask

    task automatic prog(input int c, input logic [7:0] pg, input logic [15:0] ad,
                        input logic [15:0] cn, input logic [1:0] ty, input logic au);
        host_wr(3'(c), 3'd5, 8'h00);
        host_wr(3'(c), 3'd0, ad[7:0]);
        host_wr(3'(c), 3'd0, ad[15:8]);
        host_wr(3'(c), 3'd1, cn[7:0]);
        host_wr(3'(c), 3'd1, cn[15:8]);
        host_wr(3'(c), 3'd2, pg);
        host_wr(3'(c), 3'd3, {5'd0, au, ty});
        host_wr(3'(c), 3'd4, 8'h00);
        mdl_page[c] = pg; mdl_cur[c] = ad; mdl_base[c] = ad;
        mdl_cnt[c] = cn; mdl_bcnt[c] = cn; mdl_type[c] = ty; mdl_auto[c] = au;
        mdl_mask[c] = 1'b0;
    endtask

    function automatic int exp_winner(input logic [7:0] p);
        logic [3:0] sp, mp;
        sp = p[3:0] & ~mdl_mask[3:0];
        mp = {p[7:5], |sp} & ~mdl_mask[7:4];
        if (mp == 4'd0) return -1;
        if (mp[0]) begin
            for (int i = 0; i < 4; i++) if (sp[i]) return i;
        end
        for (int i = 1; i < 4; i++) if (mp[i]) return i + 4;
        return -1;
    endfunction

    task automatic model_step(input int c, output bit tc);
        tc = (mdl_cnt[c] == 16'd0);
        if (tc && mdl_auto[c]) begin
            mdl_cur[c] = mdl_base[c];
            mdl_cnt[c] = mdl_bcnt[c];
        end else begin
            mdl_cur[c] = mdl_cur[c] + 16'd1;
            mdl_cnt[c] = mdl_cnt[c] - 16'd1;
        end
        if (tc && !mdl_auto[c]) mdl_mask[c] = 1'b1;
    endtask

    task automatic run_xfer(output logic [7:0] dk, output bit saw, output logic [23:0] ad,
                            output bit we, output bit wd, output bit tc, output int mc,
                            output bit ok);
        int n = 0;
        dk = '0; saw = 0; ad = '0; we = 0; wd = 0; tc = 0; mc = 0; ok = 0;
        while (dack == 8'd0 && n < 40) begin @(negedge clk); n++; end
        if (dack == 8'd0) return;
        dk = dack; ok = 1;
        while (dack != 8'd0 && n < 80) begin
            if (mem_req) begin saw = 1; ad = mem_addr; we = mem_we; wd = mem_word; mc++; end
            if (tc_pulse) tc = 1;
            @(negedge clk);
            n++;
        end
    endtask

    task automatic do_one(input logic [7:0] pat);
        int w;
        logic [7:0] dk, exp_dk;
        logic [23:0] ad;
        bit saw, we, wd, tc, etc, ok;
        int mc;
        w = exp_winner(pat);
        dreq = pat;
        if (w < 0) begin
            repeat (4) @(negedge clk);
            chk("R3 R5 no enabled request keeps hold low", 32'(hold_req), 32'd0);
            chk("R3 R5 no enabled request gives no dack", 32'(dack), 32'd0);
            dreq = '0;
            @(negedge clk);
            return;
        end
        run_xfer(dk, saw, ad, we, wd, tc, mc, ok);
        chk("R4 transfer started", 32'(ok), 32'd1);
        exp_dk = (8'd1 << w) | ((w < 4) ? 8'h10 : 8'h00);
        chk("R4 arbitration winner", 32'(dk), 32'(exp_dk));
        if (mdl_type[w] == 2'd1 || mdl_type[w] == 2'd2) begin
            chk("R7 memory beat issued", 32'(saw), 32'd1);
            chk("R6 physical address", 32'(ad), 32'({mdl_page[w], mdl_cur[w]}));
            chk("R7 direction", 32'(we), 32'(mdl_type[w] == 2'd1));
            chk("R6 beat width", 32'(wd), 32'(w >= 4));
            chk("R11 beat length", 32'(mc), 32'(ack_lat + 1));
        end else begin
            chk("R7 verify or illegal type makes no memory beat", 32'(saw), 32'd0);
        end
        model_step(w, etc);
        chk("R9 terminal count pulse", 32'(tc), 32'(etc));
        dreq = '0;
        @(negedge clk);
        chk("R12 release after transfer", 32'({hold_req, mem_req, dack}), 32'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        mdl_mask = 8'hFF;
        for (int i = 0; i < 8; i++) begin
            mdl_page[i] = '0; mdl_cur[i] = '0; mdl_base[i] = '0; mdl_cnt[i] = '0;
            mdl_bcnt[i] = '0; mdl_type[i] = '0; mdl_auto[i] = 1'b0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state, all lines requesting
        chk("R1 reset hold", 32'(hold_req), 32'd0);
        chk("R1 reset tc", 32'(tc_pulse), 32'd0);
        dreq = 8'hFF;
        repeat (5) @(negedge clk);
        chk("R1 masks set after reset: hold", 32'(hold_req), 32'd0);
        chk("R1 masks set after reset: dack", 32'(dack), 32'd0);
        chk("R1 masks set after reset: mem_req", 32'(mem_req), 32'd0);
        dreq = '0;

        // R1 R2: byte pointer starts at low byte, channel 1, count 0
        set_mask(4, 1'b0);
        host_wr(3'd1, 3'd0, 8'h34);
        host_wr(3'd1, 3'd0, 8'h12);
        host_wr(3'd1, 3'd2, 8'h56);
        host_wr(3'd1, 3'd3, 8'h02);
        host_wr(3'd1, 3'd4, 8'h00);
        mdl_page[1] = 8'h56; mdl_cur[1] = 16'h1234; mdl_base[1] = 16'h1234;
        mdl_type[1] = 2'd2; mdl_mask[1] = 1'b0;
        do_one(8'h02);
        do_one(8'h02);  // R9: mask now set, no transfer

        // R2 explicit flip-flop clear on the master
        host_wr(3'd6, 3'd0, 8'hAA);
        host_wr(3'd6, 3'd5, 8'h00);
        host_wr(3'd6, 3'd0, 8'h77);
        host_wr(3'd6, 3'd0, 8'h99);
        host_wr(3'd6, 3'd1, 8'h05);
        host_wr(3'd6, 3'd1, 8'h00);
        host_wr(3'd6, 3'd2, 8'h0C);
        host_wr(3'd6, 3'd3, 8'h01);
        host_wr(3'd6, 3'd4, 8'h00);
        mdl_page[6] = 8'h0C; mdl_cur[6] = 16'h9977; mdl_base[6] = 16'h9977;
        mdl_cnt[6] = 16'd5; mdl_bcnt[6] = 16'd5; mdl_type[6] = 2'd1; mdl_mask[6] = 1'b0;
        do_one(8'h40);
        chk("R2 flip-flop cleared address", 32'(mdl_cur[6]), 32'h9978);

        // R8 R9 R10 per-channel sweep across the 16-bit address wrap
        for (int c = 0; c < 8; c++) begin
            if (c == 4) continue;
            prog(c, 8'h20 + 8'(c), 16'hFFFE, 16'd2,
                 (c % 3 == 0) ? 2'd1 : ((c % 3 == 1) ? 2'd2 : 2'd0), c[0]);
            for (int k = 0; k < 4; k++) do_one(8'd1 << c);
            chk("R10 R9 mask after count expiry", 32'(u_dut.hold_req), 32'd0);
        end

        // R4 R5 priority sweep, cascade enabled then masked
        for (int c = 0; c < 8; c++) begin
            if (c == 4) continue;
            prog(c, 8'h80 | 8'(c), 16'h0100 * 16'(c) + 16'h0010, 16'hFFFF,
                 (c == 7) ? 2'd3 : 2'(c % 3), 1'b0);
        end
        for (int p = 0; p < 256; p++) do_one(8'(p));
        set_mask(4, 1'b1);
        for (int p = 0; p < 256; p++) do_one(8'(p));
        set_mask(4, 1'b0);

        // R13 grant withheld
        hold_ack = 1'b0;
        dreq = 8'h20;
        repeat (10) @(negedge clk);
        chk("R3 hold raised without grant", 32'(hold_req), 32'd1);
        chk("R13 no dack without grant", 32'(dack), 32'd0);
        chk("R13 no memory beat without grant", 32'(mem_req), 32'd0);
        hold_ack = 1'b1;
        do_one(8'h20);

        // R11 slow memory
        ack_lat = 3;
        do_one(8'h20);
        do_one(8'h01);
        do_one(8'h02);
        ack_lat = 0;
        do_one(8'h20);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule